// File: doc/BRIEF.md
# Serial Audio Receiver with Mono and Loop-back

This block turns the serial audio data line into parallel sample words. The clock/frame logic supplies a one-cycle `bit_tick` strobe for each serial bit and the word-select level `ws`. A change of `ws` marks a slot boundary. The bit after the change is the MSB of the new slot. A low `ws` means a left slot and a high `ws` means a right slot. The receiver shifts in the configured number of bits and ignores the rest of the slot. When the slot ends it emits the word right-justified and zero-extended to 32 bits.

Six plain word lengths are supported, plus two packed formats. In the packed formats a left/right pair of 16-bit or 8-bit samples shares one output word. A mono option repeats the left sample as the right sample. A loop-back option takes the bit stream from the transmit data line instead of the input pin. Words leave through a single-entry valid/ready holding register with a channel tag. If a new word arrives while the previous one is still waiting, the new word replaces it and a one-cycle overrun pulse is raised.

Top module: `serial_audio_rx`

## Requirements
- R1: During and right after reset, `out_valid` and `overrun` are 0.
- R2: `cfg_len` selects the word length: 0=32, 1=24, 2=20, 3=18, 4=16, 5=16 packed, 6=8, 7=8 packed bits. The first bit after a `ws` change is the MSB. Bits after the word length are ignored. `out_data` holds the word right-justified and zero-extended.
- R3: `out_right` is 0 for a word captured in a slot with `ws` low and 1 for a slot with `ws` high.
- R4: A slot is 32 bit ticks long. It is 24 when `cfg_slot24`=1 and `cfg_len` is 1, 2 or 3. `out_valid` rises one clock after the tick that carries the last bit of the slot.
- R5: With `cfg_mono`=1, the right-slot output carries the word captured in the preceding left slot.
- R6: For `cfg_len`=5 or 7, one word is emitted per frame, at the end of the right slot, with tag 1. The left sample is in bits [L-1:0] and the right sample in bits [2L-1:L], where L is 16 or 8. The upper bits are zero.
- R7: With `cfg_loop`=1, bits come from `sd_loop` and `sd_pin` has no effect. With `cfg_loop`=0, bits come from `sd_pin` and `sd_loop` has no effect.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_right` hold until a new word completes. Each word is delivered once.
- R9: When a word completes while `out_valid`=1 and `out_ready`=0, `overrun` pulses for one clock and the new word replaces the held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit |
| ws | input | 1 | Word-select level, sampled on `bit_tick` |
| sd_pin | input | 1 | Serial data from the pin |
| sd_loop | input | 1 | Serial data from the local transmitter |
| cfg_len | input | 3 | Word length / packing code |
| cfg_slot24 | input | 1 | 24-bit slots for 18/20/24-bit words |
| cfg_mono | input | 1 | Repeat left sample as right |
| cfg_loop | input | 1 | Take data from `sd_loop` |
| out_ready | input | 1 | Consumer ready |
| out_valid | output | 1 | Word available |
| out_data | output | 32 | Received word |
| out_right | output | 1 | Channel tag, 1 = right |
| overrun | output | 1 | One-cycle pulse: held word overwritten |

## Verification
The assertions take two things for granted about the inputs. `bit_tick` is a single-cycle pulse. The configuration inputs change only between a right slot's last bit and the next left MSB. The bench sets every configuration after a frame returns and before the next tick, so each frame is received under one setting. It keeps frames back to back, with a `ws` change on the last bit of every slot and slot lengths that match the configured width, so short or stray slots never occur.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int SAR_WORD_W = 32;
  localparam int SAR_CNT_W  = $clog2(SAR_WORD_W) + 1;

  typedef enum logic [2:0] {
    LEN_32 = 3'd0, LEN_24 = 3'd1, LEN_20 = 3'd2, LEN_18 = 3'd3,
    LEN_16 = 3'd4, LEN_16_PACK = 3'd5, LEN_8 = 3'd6, LEN_8_PACK = 3'd7
  } len_code_t;

  // number of significant bits kept from a slot
  function automatic logic [SAR_CNT_W-1:0] word_bits(input logic [2:0] code);
    case (len_code_t'(code))
      LEN_32:                 word_bits = SAR_CNT_W'(32);
      LEN_24:                 word_bits = SAR_CNT_W'(24);
      LEN_20:                 word_bits = SAR_CNT_W'(20);
      LEN_18:                 word_bits = SAR_CNT_W'(18);
      LEN_16, LEN_16_PACK:    word_bits = SAR_CNT_W'(16);
      default:                word_bits = SAR_CNT_W'(8);
    endcase
  endfunction

  // slot length in bit ticks
  function automatic logic [SAR_CNT_W-1:0] slot_bits(input logic [2:0] code,
                                                     input logic short_slot);
    logic mid;
    mid = (code == LEN_24) || (code == LEN_20) || (code == LEN_18);
    slot_bits = (mid && short_slot) ? SAR_CNT_W'(24) : SAR_CNT_W'(32);
  endfunction

  function automatic logic is_packed(input logic [2:0] code);
    is_packed = (code == LEN_16_PACK) || (code == LEN_8_PACK);
  endfunction

  function automatic logic [SAR_WORD_W-1:0] pack_pair(input logic [2:0] code,
                                                      input logic [SAR_WORD_W-1:0] lft,
                                                      input logic [SAR_WORD_W-1:0] rgt);
    if (code == LEN_16_PACK) pack_pair = {rgt[15:0], lft[15:0]};
    else                     pack_pair = {16'h0000, rgt[7:0], lft[7:0]};
  endfunction
endpackage

// File: rtl/sar_slot_timer.sv
module sar_slot_timer
  import sar_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_tick,
  input  logic                 ws,
  input  logic [SAR_CNT_W-1:0] slot_len,
  output logic                 bit_act,
  output logic [SAR_CNT_W-1:0] bit_idx,
  output logic                 slot_done,
  output logic                 slot_right
);
  logic                 ws_q, pend_q, active_q, chan_q;
  logic [SAR_CNT_W-1:0] cnt_q;

  always_comb begin
    bit_act    = bit_tick && (pend_q || active_q);
    bit_idx    = pend_q ? '0 : cnt_q;
    slot_done  = bit_act && (bit_idx == slot_len - SAR_CNT_W'(1));
    slot_right = pend_q ? ws_q : chan_q;
  end

  // ws_q resets high so that a low ws after reset opens a left slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q <= 1'b1; pend_q <= 1'b0; active_q <= 1'b0;
      chan_q <= 1'b0; cnt_q <= '0;
    end else if (bit_tick) begin
      ws_q   <= ws;
      pend_q <= (ws != ws_q);
      if (bit_act) begin
        cnt_q    <= bit_idx + SAR_CNT_W'(1);
        chan_q   <= slot_right;
        active_q <= !slot_done;
      end
    end
  end
endmodule

// File: rtl/sar_word_shift.sv
module sar_word_shift
  import sar_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_act,
  input  logic [SAR_CNT_W-1:0]  bit_idx,
  input  logic [SAR_CNT_W-1:0]  word_len,
  input  logic                  sd,
  output logic [SAR_WORD_W-1:0] word_now
);
  logic [SAR_WORD_W-1:0] acc_q;

  always_comb begin
    if (bit_idx == '0)          word_now = {{(SAR_WORD_W-1){1'b0}}, sd};
    else if (bit_idx < word_len) word_now = {acc_q[SAR_WORD_W-2:0], sd};
    else                        word_now = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (bit_act) acc_q <= word_now;
  end
endmodule

// File: rtl/sar_assembler.sv
module sar_assembler
  import sar_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot_done,
  input  logic                  slot_right,
  input  logic [SAR_WORD_W-1:0] word_now,
  input  logic [2:0]            cfg_len,
  input  logic                  cfg_mono,
  input  logic                  out_ready,
  output logic                  emit,
  output logic                  out_valid,
  output logic [SAR_WORD_W-1:0] out_data,
  output logic                  out_right,
  output logic                  overrun
);
  logic [SAR_WORD_W-1:0] left_q, right_val, emit_data;
  logic                  packed_mode;

  always_comb begin
    packed_mode = is_packed(cfg_len);
    emit        = slot_done && (slot_right || !packed_mode);
    right_val   = cfg_mono ? left_q : word_now;
    if (packed_mode)     emit_data = pack_pair(cfg_len, left_q, right_val);
    else if (slot_right) emit_data = right_val;
    else                 emit_data = word_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0; out_valid <= 1'b0; out_data <= '0;
      out_right <= 1'b0; overrun <= 1'b0;
    end else begin
      if (slot_done && !slot_right) left_q <= word_now;
      overrun <= emit && out_valid && !out_ready;
      if (emit) begin
        out_valid <= 1'b1;
        out_data  <= emit_data;
        out_right <= slot_right;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_tick,
  input  logic                  ws,
  input  logic                  sd_pin,
  input  logic                  sd_loop,
  input  logic [2:0]            cfg_len,
  input  logic                  cfg_slot24,
  input  logic                  cfg_mono,
  input  logic                  cfg_loop,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [SAR_WORD_W-1:0] out_data,
  output logic                  out_right,
  output logic                  overrun
);
  logic                  sd_sel, bit_act, slot_done, slot_right, emit;
  logic [SAR_CNT_W-1:0]  bit_idx, slot_len, word_len;
  logic [SAR_WORD_W-1:0] word_now;

  assign sd_sel   = cfg_loop ? sd_loop : sd_pin;
  assign slot_len = slot_bits(cfg_len, cfg_slot24);
  assign word_len = word_bits(cfg_len);

  sar_slot_timer u_timer (
    .clk, .rst_n, .bit_tick, .ws, .slot_len,
    .bit_act, .bit_idx, .slot_done, .slot_right
  );

  sar_word_shift u_shift (
    .clk, .rst_n, .bit_act, .bit_idx, .word_len, .sd(sd_sel), .word_now
  );

  sar_assembler u_asm (
    .clk, .rst_n, .slot_done, .slot_right, .word_now, .cfg_len, .cfg_mono,
    .out_ready, .emit, .out_valid, .out_data, .out_right, .overrun
  );
endmodule

// File: rtl/sar_checker.sv
module sar_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bit_tick,
  input logic [2:0]  cfg_len,
  input logic        out_ready,
  input logic        out_valid,
  input logic [31:0] out_data,
  input logic        out_right,
  input logic        overrun,
  input logic        slot_done,
  input logic        slot_right,
  input logic        emit
);
  p_idle_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && !overrun);

  p_done_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done |-> bit_tick);

  p_emit_shows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> out_valid);

  p_packed_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
    emit && (cfg_len == 3'd5 || cfg_len == 3'd7) |-> slot_right);

  p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !emit |=> $stable(out_data) && $stable(out_right));

  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(out_valid) && !$past(out_ready));

  p_overrun_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun || $past(emit));
endmodule

bind serial_audio_rx sar_checker u_sar_checker (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg_len(cfg_len),
  .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
  .out_right(out_right), .overrun(overrun), .slot_done(slot_done),
  .slot_right(slot_right), .emit(emit)
);

// File: tb/serial_audio_rx_bench.sv
`timescale 1ns/1ps
module serial_audio_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 1'b0, ws = 1'b0, sd_pin = 1'b0, sd_loop = 1'b0;
  logic [2:0] cfg_len = 3'd0;
  logic cfg_slot24 = 1'b0, cfg_mono = 1'b0, cfg_loop = 1'b0, out_ready = 1'b1;
  logic out_valid, out_right, overrun;
  logic [31:0] out_data;

  int n_chk = 0, n_bad = 0, tk = 0, nget = 0, ovr_cnt = 0;
  bit finished = 1'b0;
  logic [31:0] got_data [0:7];
  logic        got_tag  [0:7];
  int          got_tick [0:7];

  always #4 clk = ~clk;

  serial_audio_rx u_serial_audio_rx (
    .clk, .rst_n, .bit_tick, .ws, .sd_pin, .sd_loop, .cfg_len, .cfg_slot24,
    .cfg_mono, .cfg_loop, .out_ready, .out_valid, .out_data, .out_right, .overrun
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && nget < 8) begin
      got_data[nget] = out_data; got_tag[nget] = out_right; got_tick[nget] = tk;
      nget++;
    end
    if (rst_n && overrun) ovr_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (len %0d s24 %0d mono %0d loop %0d)",
               req, act, exp, cfg_len, cfg_slot24, cfg_mono, cfg_loop);
    end
  endtask

  function automatic int m_len(input int c);
    int t [8] = '{32, 24, 20, 18, 16, 16, 8, 8};
    return t[c];
  endfunction
  function automatic int m_slot(input int c, input bit s24);
    return (s24 && c >= 1 && c <= 3) ? 24 : 32;
  endfunction
  function automatic logic [31:0] m_mask(input logic [31:0] v, input int n);
    logic [63:0] w;
    w = (64'd1 << n) - 64'd1;
    return v & w[31:0];
  endfunction

  task automatic send_bit(input logic wsv, input logic b);
    @(negedge clk);
    ws = wsv; bit_tick = 1'b1;
    sd_loop = cfg_loop ? b : ~b;
    sd_pin  = cfg_loop ? ~b : b;
    @(posedge clk); tk++;
    @(negedge clk); bit_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [31:0] lw, input logic [31:0] rw);
    int len, slot;
    logic [31:0] w;
    len = m_len(int'(cfg_len)); slot = m_slot(int'(cfg_len), cfg_slot24);
    for (int ch = 0; ch < 2; ch++) begin
      w = (ch == 0) ? lw : rw;
      for (int i = 0; i < slot; i++)
        send_bit((i == slot - 1) ? logic'(ch == 0) : logic'(ch == 1),
                 (i < len) ? w[len - 1 - i] : 1'b1);
    end
  endtask

  task automatic run_case(input logic [31:0] lw, input logic [31:0] rw);
    int len, slot, tk0;
    logic [31:0] el, er, ep;
    len = m_len(int'(cfg_len)); slot = m_slot(int'(cfg_len), cfg_slot24);
    tk0 = tk; nget = 0;
    send_frame(lw, rw);
    el = m_mask(lw, len);
    er = cfg_mono ? el : m_mask(rw, len);
    if (cfg_len == 3'd5 || cfg_len == 3'd7) begin
      ep = el + (er << len);
      chk(nget == 1, "R6 count", nget, 1);
      chk(got_data[0] == ep, "R6 packed", got_data[0], ep);
      chk(got_tag[0] == 1'b1, "R6 tag", {31'b0, got_tag[0]}, 1);
      chk(got_tick[0] == tk0 + 2 * slot, "R4 packed timing", got_tick[0], tk0 + 2 * slot);
    end else begin
      chk(nget == 2, "R4 count", nget, 2);
      chk(got_data[0] == el, "R2 R7 left", got_data[0], el);
      chk(got_data[1] == er, cfg_mono ? "R5 mono right" : "R2 R7 right", got_data[1], er);
      chk(got_tag[0] == 1'b0 && got_tag[1] == 1'b1, "R3 tags",
          {30'b0, got_tag[0], got_tag[1]}, 32'h1);
      chk(got_tick[0] == tk0 + slot, "R4 left timing", got_tick[0], tk0 + slot);
      chk(got_tick[1] == tk0 + 2 * slot, "R4 right timing", got_tick[1], tk0 + 2 * slot);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] lw, rw;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && overrun == 1'b0, "R1 reset", {30'b0, out_valid, overrun}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && overrun == 1'b0, "R1 after reset", {30'b0, out_valid, overrun}, 0);
    send_bit(1'b0, 1'b0);  // ws falls: next tick opens the first left slot
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 2; s++)
        for (int m = 0; m < 2; m++)
          for (int lp = 0; lp < 2; lp++)
            for (int p = 0; p < 2; p++) begin
              cfg_len = 3'(c); cfg_slot24 = 1'(s); cfg_mono = 1'(m); cfg_loop = 1'(lp);
              lw = 32'hA5C3_9E17 ^ (32'(c * 16 + s * 8 + m * 4 + lp * 2 + p) * 32'h1234_5679);
              rw = {lw[12:0], lw[31:13]} ^ 32'h5A5A_F00F;
              run_case(lw, rw);
            end
    chk(ovr_cnt == 0, "R9 no overrun when ready", ovr_cnt, 0);
    // stall: left word held, right word overwrites it
    cfg_len = 3'd0; cfg_slot24 = 1'b0; cfg_mono = 1'b0; cfg_loop = 1'b0;
    out_ready = 1'b0; nget = 0;
    send_frame(32'h1357_9BDF, 32'hCAFE_0042);
    chk(out_valid == 1'b1, "R8 held valid", {31'b0, out_valid}, 1);
    chk(out_data == 32'hCAFE_0042 && out_right, "R9 newest kept", out_data, 32'hCAFE_0042);
    chk(ovr_cnt == 1, "R9 overrun pulse", ovr_cnt, 1);
    repeat (10) @(negedge clk);
    chk(out_valid && out_data == 32'hCAFE_0042, "R8 stable under stall", out_data, 32'hCAFE_0042);
    chk(nget == 0, "R8 nothing delivered while stalled", nget, 0);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(nget == 1 && got_data[0] == 32'hCAFE_0042, "R8 delivered once", got_data[0], 32'hCAFE_0042);
    chk(out_valid == 1'b0, "R8 cleared after handshake", {31'b0, out_valid}, 0);
    chk(ovr_cnt == 1, "R9 single pulse", ovr_cnt, 1);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule